// File: doc/BRIEF.md
# Programmable Interval Timer Channel

This block is a single 16-bit down-counter with six selectable counting behaviours. It is used as an interrupt timer, a rate generator, a square-wave source or a one-shot. The counter advances only on cycles where a one-cycle tick enable is high. Because the tick is derived from the system clock, the whole channel stays in one clock domain. A gate input either suspends counting or, in the retriggerable modes, restarts the count on its rising edge. The output line signals terminal count in the form the selected mode calls for.

Software-side logic outside this block programs the channel with a single-cycle load strobe. The strobe carries a 3-bit mode code, a decimal/binary select and the 16-bit initial count. The live counter value is exposed at all times, so the surrounding logic can read it back.

Top module: `pit_channel`

## Requirements
- R1: After reset and before the first load, `timer_out` is 0 and `count_value` is 0, and ticks and gate activity have no effect on either.
- R2: A load strobe places `load_value` on `count_value` in the next cycle. Mode codes 0 to 5 select the modes below. Code 6 behaves as mode 2 and code 7 behaves as mode 3. `load_bcd`=1 selects decimal counting.
- R3: Each enabled tick lowers the count by one. In modes 0, 1, 4 and 5 the count wraps from 0 to 0xFFFF (binary) or 0x9999 (decimal) and keeps going. An initial count of 0 lasts 65536 ticks in binary and 10000 ticks in decimal.
- R4: In decimal counting each nibble of `count_value` is a digit from 0 to 9, and a decrement borrows from the next higher digit.
- R5: Mode 0: `timer_out` goes low on load and goes high on the N-th enabled tick, where N is the initial count. It stays high until the next load. While gate is low, ticks do not count.
- R6: Mode 1: after load, `timer_out` is high and the count holds. A gate rising edge reloads the count and drives the output low. After that, every tick counts whatever the gate level, and the output goes high on the N-th tick.
- R7: Mode 2: `timer_out` is low. On the N-th tick the count reloads to N and the output is high until the next tick. Nothing is emitted at load time.
- R8: Mode 3 (N of at least 2): the count steps by two per tick. Within each N-tick period, `timer_out` is high for the first (N+1)/2 ticks (integer division) and low for the rest. While gate is low the count holds and the output is forced high.
- R9: Mode 4: counting is enabled by gate. `timer_out` is high for one tick interval from the N-th tick after load, and it does not pulse again after the count wraps.
- R10: Mode 5: the count holds after load until a gate rising edge. That edge reloads N and arms one output pulse on the N-th tick, with the gate level ignored from then on.
- R11: In modes 1, 2, 3 and 5, a gate rising edge reloads the initial count. In modes 0 and 4, the gate only enables or disables counting.
- R12: When several events fall in one cycle, a load takes priority over a gate rising edge, and a gate rising edge takes priority over a tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick_en | input | 1 | One-cycle count enable |
| gate_in | input | 1 | Gate level; rising edge detected internally |
| load_stb | input | 1 | Programming strobe |
| load_mode | input | 3 | Mode code, 6 and 7 alias 2 and 3 |
| load_bcd | input | 1 | 1 = decimal counting, 0 = binary |
| load_value | input | 16 | Initial count, 0 meaning the maximum |
| timer_out | output | 1 | Channel output line |
| count_value | output | 16 | Live counter value |

## Verification
The hardest situations to reach are the ones that only appear after a full wrap of the counter. One is the initial count of zero running its whole 65536 or 10000 ticks. The other is the single-shot modes staying quiet when the count passes through zero a second time. The stimulus reaches both with long directed runs of back-to-back ticks, using decimal counting where it can to keep the second case short. Odd and even square-wave periods are walked tick by tick. Random loads over modes, aliases and number bases are then checked against closed-form expectations based on the elapsed tick count.

// File: rtl/pit_pkg.sv
package pit_pkg;
  parameter int unsigned PIT_W = 16;
  localparam int unsigned PIT_DIGITS = PIT_W / 4;

  typedef enum logic [2:0] {
    MD_TERM    = 3'd0,
    MD_ONESHOT = 3'd1,
    MD_RATE    = 3'd2,
    MD_SQUARE  = 3'd3,
    MD_SWSTB   = 3'd4,
    MD_HWSTB   = 3'd5
  } pit_mode_e;

  typedef struct packed {
    pit_mode_e        mode;
    logic             bcd;
    logic [PIT_W-1:0] init;
  } pit_cfg_t;

  // codes 6 and 7 fold onto the periodic modes
  function automatic pit_mode_e fold_mode(input logic [2:0] code);
    if (code[2:1] == 2'b11) return pit_mode_e'({1'b0, code[1:0]});
    return pit_mode_e'(code);
  endfunction
endpackage

// File: rtl/pit_step_dec.sv
module pit_step_dec
  import pit_pkg::*;
(
  input  logic [PIT_W-1:0] val,
  input  logic             bcd,
  input  logic [1:0]       amt,
  output logic [PIT_W-1:0] res
);
  localparam int unsigned ND = PIT_DIGITS;

  logic [ND-1:0]    brw;
  logic [PIT_W-1:0] dec_res;
  logic [PIT_W-1:0] bin_res;

  assign brw[0]  = 1'b0;
  assign bin_res = val - PIT_W'(amt);

  for (genvar g = 0; g < ND; g++) begin : g_dig
    logic [4:0] dig;
    logic [4:0] need;
    logic [4:0] diff;
    logic       lt;
    assign dig  = {1'b0, val[4*g +: 4]};
    assign need = ((g == 0) ? {3'b000, amt} : 5'd0) + {4'b0000, brw[g]};
    assign lt   = dig < need;
    assign diff = lt ? (dig + 5'd10 - need) : (dig - need);
    assign dec_res[4*g +: 4] = diff[3:0];
    if (g < ND - 1) begin : g_chain
      assign brw[g+1] = lt;
    end
  end

  assign res = bcd ? dec_res : bin_res;
endmodule

// File: rtl/pit_cfg.sv
module pit_cfg
  import pit_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_stb,
  input  pit_mode_e        ld_mode,
  input  logic             ld_bcd,
  input  logic [PIT_W-1:0] ld_value,
  output pit_cfg_t         cfg,
  output logic             programmed
);
  pit_cfg_t cfg_q, cfg_n;
  logic     prog_q, prog_n;

  always_comb begin
    cfg_n  = cfg_q;
    prog_n = prog_q;
    if (load_stb) begin
      cfg_n.mode = ld_mode;
      cfg_n.bcd  = ld_bcd;
      cfg_n.init = ld_value;
      prog_n     = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= '{mode: MD_TERM, bcd: 1'b0, init: '0};
      prog_q <= 1'b0;
    end else begin
      cfg_q  <= cfg_n;
      prog_q <= prog_n;
    end
  end

  assign cfg        = cfg_q;
  assign programmed = prog_q;
endmodule

// File: rtl/pit_core.sv
module pit_core
  import pit_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic             gate_in,
  input  logic             load_stb,
  input  pit_mode_e        ld_mode,
  input  logic [PIT_W-1:0] ld_value,
  input  pit_cfg_t         cfg,
  input  logic             programmed,
  output logic             out_o,
  output logic [PIT_W-1:0] cnt_o
);
  localparam logic [PIT_W-1:0] ONE = PIT_W'(1);
  localparam logic [PIT_W-1:0] TWO = PIT_W'(2);

  logic [PIT_W-1:0] cnt_q, cnt_n;
  logic             out_q, out_n;
  logic             run_q, run_n;
  logic             fired_q, fired_n;
  logic             gate_q;

  logic [PIT_W-1:0] cnt_step, init_m1, low_reload;
  logic             is_square, gate_rise, restart_mode, gate_free, cnt_en;
  logic             at_one, sq_end, pulse_mode;

  assign is_square = (cfg.mode == MD_SQUARE);

  pit_step_dec u_step (
    .val (cnt_q),
    .bcd (cfg.bcd),
    .amt (is_square ? 2'd2 : 2'd1),
    .res (cnt_step)
  );

  pit_step_dec u_low (
    .val (cfg.init),
    .bcd (cfg.bcd),
    .amt (2'd1),
    .res (init_m1)
  );

  assign low_reload   = cfg.init[0] ? init_m1 : cfg.init;
  assign gate_rise    = gate_in & ~gate_q;
  assign restart_mode = (cfg.mode == MD_ONESHOT) | (cfg.mode == MD_RATE) |
                        (cfg.mode == MD_SQUARE)  | (cfg.mode == MD_HWSTB);
  assign gate_free    = (cfg.mode == MD_ONESHOT) | (cfg.mode == MD_HWSTB);
  assign cnt_en       = run_q & (gate_in | gate_free);
  assign at_one       = (cnt_q == ONE);
  assign sq_end       = at_one | (cnt_q == TWO);
  assign pulse_mode   = (cfg.mode == MD_RATE) | (cfg.mode == MD_SWSTB) |
                        (cfg.mode == MD_HWSTB);

  always_comb begin
    cnt_n   = cnt_q;
    out_n   = out_q;
    run_n   = run_q;
    fired_n = fired_q;
    if (load_stb) begin
      cnt_n   = ld_value;
      fired_n = 1'b0;
      out_n   = (ld_mode == MD_ONESHOT) | (ld_mode == MD_SQUARE);
      run_n   = !((ld_mode == MD_ONESHOT) | (ld_mode == MD_HWSTB));
    end else if (programmed && gate_rise && restart_mode) begin
      cnt_n   = cfg.init;
      run_n   = 1'b1;
      fired_n = 1'b0;
      out_n   = is_square;
    end else if (programmed) begin
      if (is_square && !gate_in) out_n = 1'b1;
      if (tick_en) begin
        if (pulse_mode) out_n = 1'b0;
        if (cnt_en) begin
          case (cfg.mode)
            MD_TERM, MD_ONESHOT: begin
              cnt_n = cnt_step;
              if (at_one) out_n = 1'b1;
            end
            MD_RATE: begin
              if (at_one) begin
                cnt_n = cfg.init;
                out_n = 1'b1;
              end else begin
                cnt_n = cnt_step;
              end
            end
            MD_SQUARE: begin
              if (sq_end) begin
                out_n = ~out_q;
                cnt_n = out_q ? low_reload : cfg.init;
              end else begin
                cnt_n = cnt_step;
              end
            end
            MD_SWSTB, MD_HWSTB: begin
              cnt_n = cnt_step;
              if (at_one && !fired_q) begin
                out_n   = 1'b1;
                fired_n = 1'b1;
              end
            end
            default: cnt_n = cnt_q;
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      out_q   <= 1'b0;
      run_q   <= 1'b0;
      fired_q <= 1'b0;
      gate_q  <= 1'b0;
    end else begin
      cnt_q   <= cnt_n;
      out_q   <= out_n;
      run_q   <= run_n;
      fired_q <= fired_n;
      gate_q  <= gate_in;
    end
  end

  assign out_o = out_q;
  assign cnt_o = cnt_q;
endmodule

// File: rtl/pit_channel.sv
module pit_channel
  import pit_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic             gate_in,
  input  logic             load_stb,
  input  logic [2:0]       load_mode,
  input  logic             load_bcd,
  input  logic [PIT_W-1:0] load_value,
  output logic             timer_out,
  output logic [PIT_W-1:0] count_value
);
  logic [1:0] rst_sync_q;
  logic       core_rst_n;
  pit_mode_e  ld_mode;
  pit_cfg_t   cfg;
  logic       programmed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign core_rst_n = rst_sync_q[1];

  assign ld_mode = fold_mode(load_mode);

  pit_cfg u_cfg (
    .clk        (clk),
    .rst_n      (core_rst_n),
    .load_stb   (load_stb),
    .ld_mode    (ld_mode),
    .ld_bcd     (load_bcd),
    .ld_value   (load_value),
    .cfg        (cfg),
    .programmed (programmed)
  );

  pit_core u_core (
    .clk        (clk),
    .rst_n      (core_rst_n),
    .tick_en    (tick_en),
    .gate_in    (gate_in),
    .load_stb   (load_stb),
    .ld_mode    (ld_mode),
    .ld_value   (load_value),
    .cfg        (cfg),
    .programmed (programmed),
    .out_o      (timer_out),
    .cnt_o      (count_value)
  );
endmodule

// File: rtl/pit_channel_chk.sv
module pit_channel_chk
  import pit_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             tick_en,
  input logic             gate_in,
  input logic             load_stb,
  input logic [2:0]       load_mode,
  input logic             load_bcd,
  input logic [PIT_W-1:0] load_value,
  input logic             timer_out,
  input logic [PIT_W-1:0] count_value
);
  logic             seen_q, bcd_q, valid_q, g_q;
  pit_mode_e        mode_q;
  logic [PIT_W-1:0] init_q;

  function automatic logic digits_ok(input logic [PIT_W-1:0] v);
    for (int i = 0; i < PIT_DIGITS; i++)
      if (v[4*i +: 4] > 4'd9) return 1'b0;
    return 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q  <= 1'b0;
      bcd_q   <= 1'b0;
      valid_q <= 1'b0;
      g_q     <= 1'b0;
      mode_q  <= MD_TERM;
      init_q  <= '0;
    end else begin
      g_q <= gate_in;
      if (load_stb) begin
        seen_q  <= 1'b1;
        bcd_q   <= load_bcd;
        valid_q <= digits_ok(load_value);
        mode_q  <= fold_mode(load_mode);
        init_q  <= load_value;
      end
    end
  end

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !seen_q |-> (!timer_out && count_value == '0));

  assert_load_value_R2: assert property (@(posedge clk) disable iff (!rst_n)
    load_stb |=> count_value == $past(load_value));

  assert_step_one_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_q && mode_q == MD_TERM && !bcd_q && tick_en && gate_in && !load_stb)
    |=> count_value == PIT_W'($past(count_value) - PIT_W'(1)));

  assert_digit_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_q && bcd_q && valid_q) |-> digits_ok(count_value));

  assert_term_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_q && mode_q == MD_TERM && timer_out && !load_stb) |=> timer_out);

  assert_rate_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_q && mode_q == MD_RATE && init_q != PIT_W'(1) && timer_out &&
     tick_en && !load_stb) |=> !timer_out);

  assert_hold_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_stb && !tick_en && !(gate_in && !g_q)) |=> $stable(count_value));
endmodule

bind pit_channel pit_channel_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .tick_en     (tick_en),
  .gate_in     (gate_in),
  .load_stb    (load_stb),
  .load_mode   (load_mode),
  .load_bcd    (load_bcd),
  .load_value  (load_value),
  .timer_out   (timer_out),
  .count_value (count_value)
);

// File: tb/pit_channel_tb_top.sv
module pit_channel_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        tick_en, gate_in, load_stb, load_bcd;
  logic [2:0]  load_mode;
  logic [15:0] load_value;
  logic        timer_out;
  logic [15:0] count_value;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pit_channel dut_i (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .gate_in(gate_in),
    .load_stb(load_stb), .load_mode(load_mode), .load_bcd(load_bcd),
    .load_value(load_value), .timer_out(timer_out), .count_value(count_value)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  function automatic int enc(input int v, input bit bcd);
    if (!bcd) return v;
    return ((v / 1000) % 10) << 12 | ((v / 100) % 10) << 8 |
           ((v / 10) % 10) << 4 | (v % 10);
  endfunction

  function automatic int fold(input int m);
    return (m >= 6) ? m - 4 : m;
  endfunction

  function automatic int exp_cnt(input int m, input int n, input int k, input bit bcd);
    int lim = bcd ? 10000 : 65536;
    int v;
    int r;
    if (m == 2) begin
      r = k % n;
      v = (r == 0) ? n : n - r;
    end else begin
      v = ((n - k) % lim + lim) % lim;
    end
    return enc(v, bcd);
  endfunction

  function automatic int exp_out(input int m, input int n, input int k);
    case (m)
      0: return int'(k >= n);
      2: return int'(k > 0 && (k % n) == 0);
      3: return int'((k % n) < (n + 1) / 2);
      default: return int'(k == n);
    endcase
  endfunction

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      tick_en = 1'b1;
      @(negedge clk);
    end
    tick_en = 1'b0;
  endtask

  task automatic do_load(input int m, input bit bcd, input int v);
    load_stb = 1'b1; load_mode = 3'(m); load_bcd = bcd; load_value = 16'(v);
    @(negedge clk);
    load_stb = 1'b0;
  endtask

  task automatic pulse_gate();
    gate_in = 1'b0;
    @(negedge clk);
    gate_in = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    rst_n = 1'b0; tick_en = 1'b0; gate_in = 1'b1; load_stb = 1'b0;
    load_mode = 3'd0; load_bcd = 1'b0; load_value = 16'd0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 idle before programming
    chk("R1 reset out", timer_out, 0);
    chk("R1 reset count", count_value, 0);
    ticks(3); pulse_gate();
    chk("R1 idle out", timer_out, 0);
    chk("R1 idle count", count_value, 0);

    // R2 R5 mode 0 binary
    do_load(0, 0, 5);
    chk("R2 load count", count_value, 5);
    chk("R5 out low on load", timer_out, 0);
    ticks(4);
    chk("R5 count before term", count_value, 1);
    chk("R5 out before term", timer_out, 0);
    ticks(1);
    chk("R5 out at term", timer_out, 1);
    ticks(1);
    chk("R3 binary wrap", count_value, 16'hFFFF);
    chk("R5 out sticky", timer_out, 1);

    // R5 R11 gate in mode 0
    do_load(0, 0, 10);
    gate_in = 1'b0;
    ticks(3);
    chk("R5 gate low holds", count_value, 10);
    gate_in = 1'b1;
    ticks(1);
    chk("R11 mode0 rise no reload", count_value, 9);

    // R4 decimal
    do_load(0, 1, 16'h0012); ticks(3);
    chk("R4 digit borrow", count_value, 16'h0009);
    do_load(0, 1, 16'h1000); ticks(1);
    chk("R4 multi borrow", count_value, 16'h0999);
    do_load(0, 1, 16'h0002); ticks(3);
    chk("R3 decimal wrap", count_value, 16'h9999);

    // R3 zero means maximum
    do_load(0, 1, 0); ticks(1);
    chk("R3 dec zero first", count_value, 16'h9999);
    ticks(9998);
    chk("R3 dec zero late out", timer_out, 0);
    ticks(1);
    chk("R3 dec zero term", timer_out, 1);
    do_load(0, 0, 0); ticks(65535);
    chk("R3 bin zero count", count_value, 1);
    chk("R3 bin zero out", timer_out, 0);
    ticks(1);
    chk("R3 bin zero term", timer_out, 1);

    // R7 mode 2
    do_load(2, 0, 4); ticks(3);
    chk("R7 count pre", count_value, 1);
    chk("R7 out pre", timer_out, 0);
    ticks(1);
    chk("R7 pulse", timer_out, 1);
    chk("R7 reload", count_value, 4);
    ticks(1);
    chk("R7 pulse end", timer_out, 0);
    chk("R7 after reload", count_value, 3);
    do_load(2, 0, 5); ticks(2);
    pulse_gate();
    chk("R11 mode2 restart", count_value, 5);
    do_load(6, 0, 3); ticks(3);
    chk("R2 alias 6 pulse", timer_out, 1);
    chk("R2 alias 6 count", count_value, 3);

    // R8 mode 3 odd period
    do_load(3, 0, 5);
    chk("R8 high at load", timer_out, 1);
    for (int k = 1; k <= 10; k++) begin
      ticks(1);
      chk("R8 odd period", timer_out, exp_out(3, 5, k));
    end
    do_load(3, 0, 4); ticks(2);
    chk("R8 even low", timer_out, 0);
    gate_in = 1'b0;
    @(negedge clk);
    chk("R8 gate forces high", timer_out, 1);
    ticks(3);
    chk("R8 gate holds count", count_value, 4);
    gate_in = 1'b1;
    @(negedge clk);
    chk("R11 mode3 restart high", timer_out, 1);
    ticks(2);
    chk("R8 after restart", timer_out, 0);

    // R6 mode 1
    do_load(1, 0, 3);
    chk("R6 out high on load", timer_out, 1);
    ticks(2);
    chk("R6 waits for trigger", count_value, 3);
    pulse_gate();
    chk("R6 trigger low", timer_out, 0);
    gate_in = 1'b0;
    ticks(2);
    chk("R6 counts gate low", count_value, 1);
    chk("R6 still low", timer_out, 0);
    ticks(1);
    chk("R6 term high", timer_out, 1);
    ticks(1);
    chk("R3 mode1 wrap", count_value, 16'hFFFF);
    gate_in = 1'b1;
    @(negedge clk);
    chk("R11 mode1 retrigger", count_value, 3);
    chk("R6 retrigger low", timer_out, 0);

    // R9 mode 4
    do_load(4, 1, 2); ticks(1);
    chk("R9 before", timer_out, 0);
    ticks(1);
    chk("R9 strobe", timer_out, 1);
    ticks(1);
    chk("R9 strobe end", timer_out, 0);
    chk("R9 wrap", count_value, 16'h9999);
    ticks(9998);
    chk("R9 wrap count", count_value, 1);
    ticks(1);
    chk("R9 no second strobe", timer_out, 0);
    do_load(4, 0, 3);
    gate_in = 1'b0; ticks(2);
    chk("R11 mode4 gate holds", count_value, 3);
    gate_in = 1'b1;

    // R10 mode 5
    do_load(5, 0, 2); ticks(3);
    chk("R10 waits", count_value, 2);
    chk("R10 out low", timer_out, 0);
    pulse_gate();
    gate_in = 1'b0;
    ticks(1);
    chk("R10 count gate low", count_value, 1);
    ticks(1);
    chk("R10 strobe", timer_out, 1);
    ticks(1);
    chk("R10 strobe end", timer_out, 0);
    gate_in = 1'b1;

    // R12 priority
    @(negedge clk);
    load_stb = 1'b1; tick_en = 1'b1; load_mode = 3'd0; load_bcd = 1'b0;
    load_value = 16'd7;
    @(negedge clk);
    load_stb = 1'b0; tick_en = 1'b0;
    chk("R12 load over tick", count_value, 7);
    do_load(2, 0, 6); ticks(2);
    gate_in = 1'b0;
    @(negedge clk);
    gate_in = 1'b1; tick_en = 1'b1;
    @(negedge clk);
    tick_en = 1'b0;
    chk("R12 rise over tick", count_value, 6);

    // random loads over modes 0 2 3 4 6 7 (R2 R3 R5 R7 R8 R9)
    for (int it = 0; it < 40; it++) begin
      int pick = $urandom_range(5, 0);
      int code = (pick == 0) ? 0 : (pick == 1) ? 2 : (pick == 2) ? 3 :
                 (pick == 3) ? 4 : (pick == 4) ? 6 : 7;
      int m = fold(code);
      bit bcd = 1'($urandom_range(1, 0));
      int n = $urandom_range(60, 2);
      int k = $urandom_range(150, 0);
      do_load(code, bcd, enc(n, bcd));
      ticks(k);
      chk("R8 R9 random out", timer_out, exp_out(m, n, k));
      if (m != 3)
        chk("R3 R7 random count", count_value, exp_cnt(m, n, k, bcd));
    end

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule